// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

The block is the event side of a power-management controller. It holds a 16-bit event status register, a 16-bit event enable register and a 16-bit control register. It also holds a free-running power-management timer. All of these are reachable through a 64-byte I/O window. The window can be moved anywhere in a 16-bit I/O space, and it is switched on by a single configuration bit. Both settings are driven from outside, by the configuration space that owns them.

Four hardware sources set status bits: an RTC alarm, a power-button press, a global-lock release, and the timer's top bit changing value. Software acknowledges an event by writing a one to its status bit. The level-sensitive system control interrupt (SCI) is a registered OR of the status bits that are pending and enabled. Only those four source positions take part. A separate output shows when a timer-overflow notification is armed, meaning the timer event is enabled and not yet pending.

Top module: `pm_event_sci`

## Requirements
- R1: The window decodes an access only when `cfg_win_en_i` is 1 and `io_addr_i[15:6]` equals `cfg_base_i[15:6]`. Base bits 31:16 and 5:0 are ignored. Outside the window `io_hit_o` is 0, a read returns 0 and a write changes nothing.
- R2: After reset the status, enable and control registers are 0, the timer is 0 and `sci_o` is 0.
- R3: Word offsets in the window, with address bit 0 ignored: status at 0x00, enable at 0x02, control at 0x04, timer bits 15:0 at 0x08 and timer bits above 15 at 0x0A. Any other offset reads 0. The enable and control registers read back every written bit.
- R4: Only status bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) exist, and all other status bits read 0. `evt_rtc_i`, `evt_pwrbtn_i` and `evt_glbl_i` sampled high at a clock edge set bits 10, 8 and 5 at that edge.
- R5: Writing 1 to an existing status bit clears it, and writing 0 leaves it unchanged. A hardware set at the same edge wins over the clear.
- R6: The timer is a TMR_W-bit counter. It is 0 after reset, goes up by one at every clock edge and wraps to 0.
- R7: At the edge where timer bit TMR_W-1 changes value, status bit 0 is set.
- R8: At each edge, `sci_o` takes the value of the OR over bits 0, 5, 8 and 10 of (status AND enable), taken from the register values before that edge. Other enable bits have no effect.
- R9: `tmr_arm_o` is 1 exactly when enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 32 | Window base from configuration space; bits 15:6 are used |
| cfg_win_en_i | input | 1 | Window decode enable |
| io_addr_i | input | 16 | I/O byte address |
| io_rd_i | input | 1 | Read strobe |
| io_wr_i | input | 1 | Write strobe |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 16 | Read data, 0 unless a read hits the window |
| io_hit_o | output | 1 | Address falls inside an enabled window |
| evt_rtc_i | input | 1 | RTC alarm event |
| evt_pwrbtn_i | input | 1 | Power-button event |
| evt_glbl_i | input | 1 | Global-lock release event |
| sci_o | output | 1 | System control interrupt level |
| tmr_arm_o | output | 1 | Timer-overflow notification armed |

## Verification
The bench builds the block with TMR_W = 12 instead of the default 24. The timer's top bit then changes every 2048 cycles rather than every 8 million. This puts several timer-status sets, the wrap back to 0 and their SCI effects inside a short run. The window is moved between two bases and switched off during the run, so both the in-window and out-of-window decode paths are covered.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned BIT_TMR    = 0;
  localparam int unsigned BIT_GLBL   = 5;
  localparam int unsigned BIT_PWRBTN = 8;
  localparam int unsigned BIT_RTC    = 10;
  localparam logic [REG_W-1:0] STS_MASK = REG_W'((1 << BIT_TMR) | (1 << BIT_GLBL) |
                                                 (1 << BIT_PWRBTN) | (1 << BIT_RTC));
  typedef enum logic [2:0] {
    SEL_NONE, SEL_STS, SEL_EN, SEL_CTL, SEL_TLO, SEL_THI
  } reg_sel_e;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_sci_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned WIN_BITS = 6
) (
  input  logic [CFG_W-1:0]  cfg_base_i,
  input  logic              win_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output reg_sel_e          sel_o
);
  localparam int unsigned WORD_W = WIN_BITS - 1;

  logic [ADDR_W-WIN_BITS-1:0] base_page, addr_page;
  logic [WORD_W-1:0]          word;
  logic [CFG_W-ADDR_W:0]      unused_bits;

  assign base_page   = cfg_base_i[ADDR_W-1:WIN_BITS];
  assign addr_page   = addr_i[ADDR_W-1:WIN_BITS];
  assign word        = addr_i[WIN_BITS-1:1];
  assign unused_bits = {cfg_base_i[CFG_W-1:ADDR_W], addr_i[0]};
  assign hit_o       = win_en_i && (addr_page == base_page);

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o) begin
      case (word)
        WORD_W'(0): sel_o = SEL_STS;
        WORD_W'(1): sel_o = SEL_EN;
        WORD_W'(2): sel_o = SEL_CTL;
        WORD_W'(4): sel_o = SEL_TLO;
        WORD_W'(5): sel_o = SEL_THI;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_sci_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = STS_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] hw_set_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] ctl_o
);
  logic wr_sts, wr_en, wr_ctl;
  assign wr_sts = we_i && (sel_i == SEL_STS);
  assign wr_en  = we_i && (sel_i == SEL_EN);
  assign wr_ctl = we_i && (sel_i == SEL_CTL);

  for (genvar i = 0; i < REG_W; i++) begin : g_sts
    if (IMPL_MASK[i]) begin : g_impl
      logic bit_q;
      // hardware set has priority over write-one-to-clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              bit_q <= 1'b0;
        else if (hw_set_i[i])     bit_q <= 1'b1;
        else if (wr_sts && wdata_i[i]) bit_q <= 1'b0;
      end
      assign sts_o[i] = bit_q;
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      ctl_o <= '0;
    end else begin
      if (wr_en)  en_o  <= wdata_i;
      if (wr_ctl) ctl_o <= wdata_i;
    end
  end

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i[BIT_RTC] |=> sts_o[BIT_RTC]); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && wdata_i[BIT_PWRBTN] && !hw_set_i[BIT_PWRBTN]) |=> !sts_o[BIT_PWRBTN]); // R5
  AST_W0_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[BIT_GLBL] && !(wr_sts && wdata_i[BIT_GLBL])) |=> sts_o[BIT_GLBL]); // R5
  AST_EN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(en_o)); // R3
endmodule

// File: rtl/pm_free_timer.sv
module pm_free_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TMR_W-1:0] cnt_o,
  output logic             msb_flip_o
);
  // top bit changes at the next edge when all lower bits are ones
  assign msb_flip_o = &cnt_o[TMR_W-2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_o == TMR_W'($past(cnt_o) + 1'b1))); // R6
  AST_TMR_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msb_flip_o |=> (cnt_o[TMR_W-1] != $past(cnt_o[TMR_W-1]))); // R7
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
  import pm_sci_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_base_i,
  input  logic        cfg_win_en_i,
  input  logic [15:0] io_addr_i,
  input  logic        io_rd_i,
  input  logic        io_wr_i,
  input  logic [15:0] io_wdata_i,
  output logic [15:0] io_rdata_o,
  output logic        io_hit_o,
  input  logic        evt_rtc_i,
  input  logic        evt_pwrbtn_i,
  input  logic        evt_glbl_i,
  output logic        sci_o,
  output logic        tmr_arm_o
);
  localparam int unsigned EXT_W = 32;

  reg_sel_e         sel;
  logic [REG_W-1:0] sts, en, ctl, hw_set;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic [EXT_W-1:0] tmr_ext;
  logic             sci_q;

  pm_win_decode #(.ADDR_W(16), .CFG_W(32), .WIN_BITS(6)) u_dec (
    .cfg_base_i (cfg_base_i),
    .win_en_i   (cfg_win_en_i),
    .addr_i     (io_addr_i),
    .hit_o      (io_hit_o),
    .sel_o      (sel)
  );

  pm_free_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_o      (tmr_cnt),
    .msb_flip_o (tmr_flip)
  );

  always_comb begin
    hw_set             = '0;
    hw_set[BIT_TMR]    = tmr_flip;
    hw_set[BIT_GLBL]   = evt_glbl_i;
    hw_set[BIT_PWRBTN] = evt_pwrbtn_i;
    hw_set[BIT_RTC]    = evt_rtc_i;
  end

  pm_evt_regs #(.IMPL_MASK(STS_MASK)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (io_wr_i),
    .sel_i    (sel),
    .wdata_i  (io_wdata_i),
    .hw_set_i (hw_set),
    .sts_o    (sts),
    .en_o     (en),
    .ctl_o    (ctl)
  );

  assign tmr_ext = EXT_W'(tmr_cnt);

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      case (sel)
        SEL_STS: io_rdata_o = sts;
        SEL_EN:  io_rdata_o = en;
        SEL_CTL: io_rdata_o = ctl;
        SEL_TLO: io_rdata_o = tmr_ext[15:0];
        SEL_THI: io_rdata_o = tmr_ext[31:16];
        default: io_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_q <= 1'b0;
    else         sci_q <= |(sts & en & STS_MASK);
  end

  assign sci_o     = sci_q;
  assign tmr_arm_o = en[BIT_TMR] & ~sts[BIT_TMR];

  AST_SCI_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts & en & STS_MASK)) |=> sci_o); // R8
  AST_SCI_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sts & en & STS_MASK)) |=> !sci_o); // R8
  AST_TMR_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_flip |=> sts[BIT_TMR]); // R7
  AST_RD_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_hit_o |-> (io_rdata_o == '0)); // R1
  AST_ARM_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts[BIT_TMR] |-> !tmr_arm_o); // R9
endmodule

// File: tb/pm_event_sci_bench.sv
`timescale 1ns/1ps
module pm_event_sci_bench;
  localparam int TMR_W = 12;
  localparam logic [15:0] MASK = 16'h0521;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'hABCD_1240;
  logic        cfg_en = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        ev_rtc = 1'b0, ev_pb = 1'b0, ev_gl = 1'b0;
  logic [15:0] rdata;
  logic        hit, sci, arm;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pm_event_sci #(.TMR_W(TMR_W)) u_pm_event_sci (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_win_en_i(cfg_en),
    .io_addr_i(addr), .io_rd_i(rd), .io_wr_i(wr), .io_wdata_i(wdata),
    .io_rdata_o(rdata), .io_hit_o(hit), .evt_rtc_i(ev_rtc), .evt_pwrbtn_i(ev_pb),
    .evt_glbl_i(ev_gl), .sci_o(sci), .tmr_arm_o(arm)
  );

  // reference model
  logic [15:0]      m_sts, m_en, m_ctl;
  logic [TMR_W-1:0] m_cnt;
  logic             m_sci;

  function automatic logic exp_hit(input logic [15:0] a);
    return cfg_en && (a[15:6] == cfg_base[15:6]);
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    logic [31:0] t;
    t = 32'(m_cnt);
    if (!exp_hit(a)) return 16'h0;
    case (a[5:1])
      5'd0: return m_sts;
      5'd1: return m_en;
      5'd2: return m_ctl;
      5'd4: return t[15:0];
      5'd5: return t[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string auto_tag(input logic [15:0] a);
    if (!exp_hit(a)) return "R1";
    case (a[5:1])
      5'd0: return "R4";
      5'd1, 5'd2: return "R3";
      5'd4, 5'd5: return "R6";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = '0; m_en = '0; m_ctl = '0; m_cnt = '0; m_sci = 1'b0;
    end else begin
      logic [15:0] ns;
      logic        nsci;
      nsci = |(m_sts & m_en & MASK);
      ns = m_sts;
      if (wr && exp_hit(addr)) begin
        case (addr[5:1])
          5'd0: ns = ns & ~wdata;
          5'd1: m_en = wdata;
          5'd2: m_ctl = wdata;
          default: ;
        endcase
      end
      if (ev_rtc) ns[10] = 1'b1;
      if (ev_pb)  ns[8]  = 1'b1;
      if (ev_gl)  ns[5]  = 1'b1;
      if (&m_cnt[TMR_W-2:0]) ns[0] = 1'b1;
      m_sts = ns & MASK;
      m_sci = nsci;
      m_cnt = m_cnt + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic r, input logic w,
                      input logic [15:0] d, input logic [2:0] ev, input string tag);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
    {ev_rtc, ev_pb, ev_gl} = ev;
    #1;
    chk("R1", 32'(hit), 32'(exp_hit(a)));
    chk(tag == "" ? auto_tag(a) : tag, 32'(rdata), 32'(r ? exp_read(a) : 16'h0));
    chk("R8", 32'(sci), 32'(m_sci));
    chk("R9", 32'(arm), 32'(m_en[0] & ~m_sts[0]));
  endtask

  function automatic logic [15:0] wa(input logic [5:0] off);
    return {cfg_base[15:6], off};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    #1;
    chk("R2", 32'(sci), 32'h0);
    #10 rst_n = 1'b1;
    // R2 reset values
    step(wa(6'h00), 1, 0, 0, 3'b000, "R2");
    step(wa(6'h02), 1, 0, 0, 3'b000, "R2");
    step(wa(6'h04), 1, 0, 0, 3'b000, "R2");
    // R3 enable/control readback, unmapped offset, odd address
    step(wa(6'h02), 0, 1, 16'hFFFF, 3'b000, "R3");
    step(wa(6'h03), 1, 0, 0, 3'b000, "R3");
    step(wa(6'h04), 0, 1, 16'hA5C3, 3'b000, "R3");
    step(wa(6'h04), 1, 0, 0, 3'b000, "R3");
    step(wa(6'h06), 1, 0, 0, 3'b000, "R3");
    // R4 event sets, reserved bits read 0
    step(wa(6'h00), 1, 0, 0, 3'b100, "R4");
    step(wa(6'h00), 1, 0, 0, 3'b011, "R4");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R4");
    // R5 write zero keeps, write one clears, set wins over clear
    step(wa(6'h00), 0, 1, 16'h0000, 3'b000, "R5");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R5");
    step(wa(6'h00), 0, 1, 16'h0100, 3'b000, "R5");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R5");
    step(wa(6'h00), 0, 1, 16'h0400, 3'b100, "R5");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R5");
    step(wa(6'h00), 0, 1, 16'hFFFF, 3'b000, "R5");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R5");
    // R8 non-source enable bits give no SCI
    step(wa(6'h02), 0, 1, 16'hFADE, 3'b111, "R8");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R8");
    step(wa(6'h00), 1, 0, 0, 3'b000, "R8");
    step(wa(6'h02), 0, 1, 16'h0001, 3'b000, "R8");
    // R1 disabled window and foreign base ignore writes
    cfg_en = 1'b0;
    step(wa(6'h02), 0, 1, 16'h1234, 3'b000, "R1");
    step(wa(6'h02), 1, 0, 0, 3'b000, "R1");
    cfg_en = 1'b1;
    step(16'h0002, 0, 1, 16'h5678, 3'b000, "R1");
    step(wa(6'h02), 1, 0, 0, 3'b000, "R1");
    // R6 timer reads; R7 timer status over several top-bit changes
    step(wa(6'h08), 1, 0, 0, 3'b000, "R6");
    step(wa(6'h0A), 1, 0, 0, 3'b000, "R6");
    for (int i = 0; i < 4500; i++) begin
      logic [15:0] d;
      d = (i % 600 == 599) ? 16'h0001 : 16'h0000;
      step(wa(6'h00), 1, d != 0, d, 3'b000, "R7");
    end
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] a;
      logic [2:0]  ev;
      logic        r, w;
      int unsigned x;
      if (i == 3000) cfg_base = 32'h0000_FF80;
      if (i % 997 == 500) cfg_en = 1'b0;
      if (i % 997 == 530) cfg_en = 1'b1;
      x = $urandom;
      if (x[1:0] != 2'b00) a = {cfg_base[15:6], 6'($urandom_range(0, 15))};
      else a = 16'($urandom);
      ev[2] = ($urandom_range(0, 15) == 0);
      ev[1] = ($urandom_range(0, 15) == 0);
      ev[0] = ($urandom_range(0, 15) == 0);
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 3) != 0);
      if (w && x[4:2] < 3'd5) a = wa(6'h00);
      step(a, r, w, 16'($urandom), ev, "");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule